// File: doc/BRIEF.md
# Single-wire monitor serial port

This block is a half-duplex serial port that talks over one bidirectional data line. It receives and sends 8-bit characters in NRZ mark/space form: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Transmit and receive share one bit period. That period is taken from the bus clock through a fixed divisor, and a select input picks between two divisor values.

The line is driven through a tri-state pad, so the block has an output enable, an output value and an input value for it. The line idles high. The block drives it only while it is sending a character or answering a break. Received bytes appear on a data output together with a one-cycle valid strobe. Bytes to send are offered on a data input with a valid/ready handshake.

A long low period on the line, running from the start bit through the place where the stop bit should be, is treated as a break. The block answers a break in two steps: it first holds the line high for two bit times, and it then sends a break of its own. Command interpretation and memory access are handled elsewhere.

Top module: `swire_mon_port`

## Requirements
- R1: While reset is applied and just after it is released, `line_oe` is 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: When `tx_valid` and `tx_ready` are both 1 at a clock edge, `line_oe` rises after that edge. It stays high for exactly 10 bit times. During those bit times the line carries a low start bit, then `tx_data` with bit 0 first, then a high stop bit. `tx_ready` is 0 for the whole of that interval.
- R3: One bit time is 256 clocks when `div_sel` is 0 and 335 clocks when `div_sel` is 1. The same value applies to both transmit and receive.
- R4: The receiver samples each bit once, at the centre of the bit period. When a received frame ends in a high stop bit, `rx_valid` is 1 for exactly one cycle and `rx_data` holds the eight data bits, with the first bit received as bit 0.
- R5: A low pulse shorter than half a bit time is treated as noise. It produces no `rx_valid` and no line activity.
- R6: A break is a start bit followed by nine more bit times of logic 0, so that the stop bit is low and all data bits are 0. A break produces no `rx_valid`. After a break, `line_oe` rises before the tenth bit time on the line has ended, and the line is then driven high for exactly 2 bit times.
- R7: After the high interval, the block drives the line low for exactly 10 bit times, which forms the start bit plus nine zero bits. It then releases the line.
- R8: From the detection of a break until its echo ends, `tx_ready` stays 0. A transmit request that is waiting during that time is sent, unchanged, after the echo.
- R9: After a break, the receiver looks for no new start bit until the line has returned high. A line that stays low after the echo causes no new break response and no `rx_valid`.
- R10: A frame whose stop bit is low but whose data bits are not all 0 is discarded. It produces no `rx_valid` and no break response.
- R11: `line_oe` is 1 only while the block is sending a character or answering a break. The receiver ignores the line while `line_oe` is 1, so `rx_valid` never occurs while the block drives the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 1 | Bit period select: 0 gives 256 clocks, 1 gives 335 clocks |
| line_oe | output | 1 | Output enable for the line pad driver |
| line_out | output | 1 | Value driven onto the line when `line_oe` is 1 |
| line_in | input | 1 | Value read back from the line pad |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle strobe that marks a new `rx_data` |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Block can accept a transmit request |

## Verification
A divisor or bit counter that holds the wrong value moves edges on `line_out` away from the bit-time boundaries. On the receive side it shifts the centre samples into the wrong bits. A fault of this kind shows up within the first frame, either as a wrong bit pattern or as a wrong frame length counted in clocks.

A receiver that is left in the wrong state shows up as a missing or extra `rx_valid` at the stop-bit centre, about 9.5 bit times after the start edge. It can also show up as a break response that was never requested.

A fault in the break sequencer changes the counted lengths of the high-hold interval and the low echo. Those lengths can be read at the pad within 12 bit times of detection.

// File: rtl/swm_pkg.sv
package swm_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT
  } rx_state_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_HOLD,
    TX_BITS
  } tx_state_t;

  // clocks per bit for the chosen divisor
  function automatic int unsigned bit_clocks(input logic sel,
                                             input int unsigned ext_div,
                                             input int unsigned int_div);
    return sel ? int_div : ext_div;
  endfunction

  // clocks from a start edge to the centre of the start bit
  function automatic int unsigned half_clocks(input logic sel,
                                              input int unsigned ext_div,
                                              input int unsigned int_div);
    return bit_clocks(sel, ext_div, int_div) / 2;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned a,
                                            input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > 2) ? $clog2(m) : 1;
  endfunction

endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  // reset to the idle (mark) level so no false start is seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/swm_bit_timer.sv
module swm_bit_timer
  import swm_pkg::*;
#(
  parameter int unsigned DIV_EXT = 256,
  parameter int unsigned DIV_INT = 335,
  parameter int unsigned CNT_W   = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_sel,
  input  logic restart,
  input  logic half_sel,
  output logic tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    if (half_sel) lim = CNT_W'(half_clocks(div_sel, DIV_EXT, DIV_INT) - 1);
    else          lim = CNT_W'(bit_clocks(div_sel, DIV_EXT, DIV_INT) - 1);
  end

  assign tick = !restart && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swm_rx.sv
module swm_rx
  import swm_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned DIV_EXT   = 256,
  parameter int unsigned DIV_INT   = 335,
  parameter int unsigned CNT_W     = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 div_sel,
  input  logic                 rx_s,
  input  logic                 hold_off,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 brk_evt,
  output logic                 rx_idle
);
  localparam int unsigned BIT_W = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;

  rx_state_t            state;
  logic [DATA_BITS-1:0] sh;
  logic [BIT_W-1:0]     bcnt;
  logic                 tick;
  logic                 restart;
  logic                 half_sel;

  assign restart  = (state == RX_IDLE) && !rx_s && !hold_off;
  assign half_sel = (state == RX_START);
  assign rx_idle  = (state == RX_IDLE);

  swm_bit_timer #(
    .DIV_EXT(DIV_EXT),
    .DIV_INT(DIV_INT),
    .CNT_W  (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .restart (restart),
    .half_sel(half_sel),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      sh       <= '0;
      bcnt     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      brk_evt  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      brk_evt  <= 1'b0;
      if (hold_off) begin
        state <= RX_WAIT;
      end else begin
        case (state)
          RX_IDLE: if (!rx_s) state <= RX_START;
          RX_START: if (tick) begin
            if (rx_s) state <= RX_IDLE;        // noise, no start bit
            else begin
              state <= RX_DATA;
              bcnt  <= '0;
            end
          end
          RX_DATA: if (tick) begin
            sh <= {rx_s, sh[DATA_BITS-1:1]};
            if (bcnt == BIT_W'(DATA_BITS - 1)) state <= RX_STOP;
            else                               bcnt  <= bcnt + 1'b1;
          end
          RX_STOP: if (tick) begin
            if (rx_s) begin
              rx_data  <= sh;
              rx_valid <= 1'b1;
              state    <= RX_IDLE;
            end else begin
              brk_evt <= (sh == '0);           // all-zero frame = break
              state   <= RX_WAIT;
            end
          end
          RX_WAIT: if (rx_s) state <= RX_IDLE;
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/swm_tx.sv
module swm_tx
  import swm_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned HOLD_BITS = 2,
  parameter int unsigned DIV_EXT   = 256,
  parameter int unsigned DIV_INT   = 335,
  parameter int unsigned CNT_W     = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 div_sel,
  input  logic                 start_byte,
  input  logic                 start_brk,
  input  logic [DATA_BITS-1:0] byte_in,
  output logic                 line_oe,
  output logic                 line_out,
  output logic                 busy
);
  // a character and a break echo both span start + data + one more bit
  localparam int unsigned FRAME  = DATA_BITS + 2;
  localparam int unsigned FR_W   = $clog2(FRAME);
  localparam int unsigned HOLD_W = (HOLD_BITS > 2) ? $clog2(HOLD_BITS) : 1;

  tx_state_t         state;
  logic [FRAME-1:0]  sh;
  logic [FR_W-1:0]   bcnt;
  logic [HOLD_W-1:0] hcnt;
  logic              tick;
  logic              restart;

  assign restart = (state == TX_IDLE) && (start_byte || start_brk);

  swm_bit_timer #(
    .DIV_EXT(DIV_EXT),
    .DIV_INT(DIV_INT),
    .CNT_W  (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .restart (restart),
    .half_sel(1'b0),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      sh    <= '1;
      bcnt  <= '0;
      hcnt  <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (start_brk) begin
            state <= TX_HOLD;
            hcnt  <= '0;
            sh    <= '0;
          end else if (start_byte) begin
            state <= TX_BITS;
            bcnt  <= '0;
            sh    <= {1'b1, byte_in, 1'b0};
          end
        end
        TX_HOLD: if (tick) begin
          if (hcnt == HOLD_W'(HOLD_BITS - 1)) begin
            state <= TX_BITS;
            bcnt  <= '0;
            sh    <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        TX_BITS: if (tick) begin
          sh <= {1'b1, sh[FRAME-1:1]};
          if (bcnt == FR_W'(FRAME - 1)) state <= TX_IDLE;
          else                          bcnt  <= bcnt + 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign line_oe  = (state != TX_IDLE);
  assign line_out = (state == TX_HOLD) || ((state == TX_BITS) ? sh[0] : 1'b1);
  assign busy     = line_oe;
endmodule

// File: rtl/swire_mon_port.sv
module swire_mon_port
  import swm_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned DIV_EXT     = 256,
  parameter int unsigned DIV_INT     = 335,
  parameter int unsigned HOLD_BITS   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 div_sel,
  output logic                 line_oe,
  output logic                 line_out,
  input  logic                 line_in,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready
);
  localparam int unsigned CNT_W = cnt_width(DIV_EXT, DIV_INT);

  // named internal events, visible to the bound checker
  logic rx_s;
  logic brk_evt;
  logic rx_idle;
  logic tx_busy;
  logic tx_accept;

  swm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (line_in),
    .q    (rx_s)
  );

  swm_rx #(
    .DATA_BITS(DATA_BITS),
    .DIV_EXT  (DIV_EXT),
    .DIV_INT  (DIV_INT),
    .CNT_W    (CNT_W)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .rx_s    (rx_s),
    .hold_off(tx_busy),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .brk_evt (brk_evt),
    .rx_idle (rx_idle)
  );

  // half duplex: accept only when both directions are quiet
  assign tx_ready  = !tx_busy && rx_idle;
  assign tx_accept = tx_valid && tx_ready;

  swm_tx #(
    .DATA_BITS(DATA_BITS),
    .HOLD_BITS(HOLD_BITS),
    .DIV_EXT  (DIV_EXT),
    .DIV_INT  (DIV_INT),
    .CNT_W    (CNT_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_sel   (div_sel),
    .start_byte(tx_accept),
    .start_brk (brk_evt),
    .byte_in   (tx_data),
    .line_oe   (line_oe),
    .line_out  (line_out),
    .busy      (tx_busy)
  );
endmodule

// File: rtl/swm_check.sv
module swm_check
  import swm_pkg::*;
#(
  parameter int unsigned DIV_EXT   = 256,
  parameter int unsigned DIV_INT   = 335,
  parameter int unsigned HOLD_BITS = 2,
  parameter int unsigned ECHO_BITS = 10
) (
  input logic clk,
  input logic rst_n,
  input logic div_sel,
  input logic line_oe,
  input logic line_out,
  input logic rx_valid,
  input logic tx_valid,
  input logic tx_ready,
  input logic brk_evt
);
  logic        in_resp;
  int unsigned hold_cnt;
  int unsigned low_cnt;
  int unsigned per;

  assign per = bit_clocks(div_sel, DIV_EXT, DIV_INT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_resp  <= 1'b0;
      hold_cnt <= 0;
      low_cnt  <= 0;
    end else if (brk_evt) begin
      in_resp  <= 1'b1;
      hold_cnt <= 0;
      low_cnt  <= 0;
    end else begin
      if (!line_oe) in_resp <= 1'b0;
      if (in_resp && line_oe && line_out)  hold_cnt <= hold_cnt + 1;
      if (in_resp && line_oe && !line_out) low_cnt  <= low_cnt + 1;
    end
  end

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (line_oe && !line_out));

  p_brk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> (line_oe && line_out));

  p_brk_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> !rx_valid);

  p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_resp && line_oe && $fell(line_out)) |-> (hold_cnt == HOLD_BITS * per));

  p_echo_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_resp && $fell(line_oe)) |-> (low_cnt == ECHO_BITS * per));

  p_ready_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !tx_ready);

  p_quiet_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !rx_valid);
endmodule

bind swire_mon_port swm_check #(
  .DIV_EXT  (DIV_EXT),
  .DIV_INT  (DIV_INT),
  .HOLD_BITS(HOLD_BITS),
  .ECHO_BITS(DATA_BITS + 2)
) u_check (
  .clk     (clk),
  .rst_n   (rst_n),
  .div_sel (div_sel),
  .line_oe (line_oe),
  .line_out(line_out),
  .rx_valid(rx_valid),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .brk_evt (brk_evt)
);

// File: tb/test_swire_mon_port.sv
module test_swire_mon_port;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_sel = 1'b0;
  logic       line_oe;
  logic       line_out;
  logic       line_in;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       drv = 1'b1;

  int checks = 0;
  int fails  = 0;
  int per    = 256;
  int vcnt   = 0;
  int oe_rises = 0;
  logic [7:0] vdata = 8'h00;
  logic oe_q = 1'b0;

  // pad model: the block drives when enabled, otherwise the bench (pulled high)
  assign line_in = line_oe ? line_out : drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  swire_mon_port i_swire_mon_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .line_oe (line_oe),
    .line_out(line_out),
    .line_in (line_in),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .tx_data (tx_data),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt  <= vcnt + 1;
      vdata <= rx_data;
    end
    if (line_oe && !oe_q) oe_rises <= oe_rises + 1;
    oe_q <= line_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sel(input logic s);
    div_sel = s;
    per = s ? 335 : 256;
  endtask

  task automatic send_byte(input logic [7:0] b);
    drv = 1'b0; wait_n(per);
    for (int i = 0; i < 8; i++) begin drv = b[i]; wait_n(per); end
    drv = 1'b1; wait_n(per);
  endtask

  task automatic capture_frame(output int n, output logic [9:0] bits, output bit rb);
    n = 0; bits = '0; rb = 0;
    while (line_oe && n < 20 * per) begin
      if ((n % per) == per / 2 && (n / per) < 10) bits[n / per] = line_out;
      if (tx_ready) rb = 1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic capture_resp(output int hi, output int lo, output bit order_bad, output bit rb);
    hi = 0; lo = 0; order_bad = 0; rb = 0;
    while (line_oe && (hi + lo) < 20 * per) begin
      if (line_out) begin hi++; if (lo > 0) order_bad = 1; end
      else lo++;
      if (tx_ready) rb = 1;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(line_oe == 1'b0, "R1 line_oe after reset", line_oe, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid after reset", rx_valid, 0);
    chk(tx_ready == 1'b1, "R1 tx_ready after reset", tx_ready, 1);
  endtask

  task automatic t_rx(input logic [7:0] b, input logic s, input string req);
    int v0;
    set_sel(s);
    v0 = vcnt;
    send_byte(b);
    wait_n(2);
    chk(vcnt == v0 + 1, {req, " one rx_valid cycle"}, vcnt - v0, 1);
    chk(vdata == b, {req, " rx_data"}, vdata, b);
  endtask

  task automatic t_tx(input logic [7:0] b, input logic s, input string req);
    int n, g, v0;
    logic [9:0] bits;
    bit rb;
    set_sel(s);
    g = 0;
    while (!tx_ready && g < 1000) begin @(negedge clk); g++; end
    v0 = vcnt;
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(line_oe == 1'b1, {req, " oe after accept"}, line_oe, 1);
    capture_frame(n, bits, rb);
    chk(n == 10 * per, {req, " frame length"}, n, 10 * per);
    chk(bits == {1'b1, b, 1'b0}, "R2 frame bits", bits, {1'b1, b, 1'b0});
    chk(rb == 0, "R2 tx_ready low while sending", rb, 0);
    chk(vcnt == v0, "R11 no rx_valid on own frame", vcnt - v0, 0);
    wait_n(4);
    chk(line_oe == 1'b0, "R11 line released", line_oe, 0);
  endtask

  task automatic t_noise(input logic s);
    int v0, o0;
    set_sel(s);
    v0 = vcnt; o0 = oe_rises;
    drv = 1'b0; wait_n(per / 2 - 20);
    drv = 1'b1; wait_n(12 * per);
    chk(vcnt == v0, "R5 glitch gives no byte", vcnt - v0, 0);
    chk(oe_rises == o0, "R5 glitch gives no drive", oe_rises - o0, 0);
  endtask

  // start a break on the line and wait for the response to begin
  task automatic brk_start(output int n);
    drv = 1'b0; n = 0;
    while (!line_oe && n < 12 * per) begin @(negedge clk); n++; end
  endtask

  task automatic t_break(input logic s, input bit with_req);
    int n, hi, lo, v0, g;
    bit ob, rb;
    logic [9:0] bits;
    set_sel(s);
    v0 = vcnt;
    brk_start(n);
    chk(line_oe == 1'b1, "R6 break answered", line_oe, 1);
    chk(n >= (19 * per) / 2 && n < 10 * per, "R6 detection time", n, 10 * per);
    drv = 1'b1;
    if (with_req) begin tx_data = 8'h5A; tx_valid = 1'b1; end
    capture_resp(hi, lo, ob, rb);
    chk(hi == 2 * per, "R6 high hold length", hi, 2 * per);
    chk(lo == 10 * per, "R7 echo length", lo, 10 * per);
    chk(ob == 0, "R7 hold precedes echo", ob, 0);
    chk(vcnt == v0, "R6 break gives no byte", vcnt - v0, 0);
    if (with_req) begin
      chk(rb == 0, "R8 tx_ready low during response", rb, 0);
      g = 0;
      while (!line_oe && g < 200) begin @(negedge clk); g++; end
      tx_valid = 1'b0;
      capture_frame(n, bits, rb);
      chk(bits == {1'b1, 8'h5A, 1'b0}, "R8 held request sent after echo", bits, {1'b1, 8'h5A, 1'b0});
      chk(n == 10 * per, "R8 held frame length", n, 10 * per);
    end
    wait_n(4);
  endtask

  task automatic t_wait_high(input logic s);
    int n, hi, lo, v0, o0;
    bit ob, rb;
    set_sel(s);
    brk_start(n);
    capture_resp(hi, lo, ob, rb);
    v0 = vcnt; o0 = oe_rises;
    wait_n(20 * per);
    chk(oe_rises == o0, "R9 low line not seen as new break", oe_rises - o0, 0);
    chk(vcnt == v0, "R9 low line gives no byte", vcnt - v0, 0);
    drv = 1'b1; wait_n(per);
    t_rx(8'h96, s, "R9 receive after line high");
  endtask

  task automatic t_frame_err(input logic s);
    int v0, o0;
    set_sel(s);
    v0 = vcnt; o0 = oe_rises;
    drv = 1'b0; wait_n(per);
    for (int i = 0; i < 8; i++) begin drv = (i == 6); wait_n(per); end
    drv = 1'b0; wait_n(2 * per);
    drv = 1'b1; wait_n(2 * per);
    chk(vcnt == v0, "R10 bad stop gives no byte", vcnt - v0, 0);
    chk(oe_rises == o0, "R10 bad stop gives no break response", oe_rises - o0, 0);
    t_rx(8'h01, s, "R10 receive after framing error");
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_n(5);
    t_reset();
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_rx(8'hA5, 1'b0, "R4");
    t_rx(8'h3C, 1'b1, "R3 receive at 335");
    t_tx(8'hC3, 1'b0, "R2");
    t_tx(8'h81, 1'b1, "R3 send at 335");
    t_noise(1'b0);
    t_break(1'b0, 1'b0);
    t_break(1'b1, 1'b1);
    t_wait_high(1'b0);
    t_frame_err(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule